// File: doc/BRIEF.md
# UART Channel Status Flags and Interrupt Requests

This block keeps the status flags of one serial channel and produces its two interrupt request lines. A receiver core reports each finished character with a one-cycle strobe. The strobe comes with the character and with two error qualifiers, one for a bad stop bit and one for a parity mismatch. A transmitter core reports the cycle in which it copies the pending character into its shift register.

Towards the CPU the block holds the received-data register and the transmit holding register. Data reads and writes arrive as single-cycle strobes. A small control register carries the two interrupt enables and an error-clear bit, and writing 0 to that bit wipes all three receive error flags at once.

The receive request combines a data-ready condition with three error conditions. Data-ready is cleared by reading the received data. The error flags are cleared only by the error-clear write. Both interrupt lines are levels.

Top module: `uart_flag_irq`

## Requirements
- R1: `irq_rx` is 1 exactly when the receive enable (control bit 0) is 1 and at least one of data-ready, overrun, framing error or parity error is set; it drops within one cycle of a control write that puts 0 in bit 0.
- R2: A `rx_done` strobe while data-ready is 0 loads `rx_char` into the received-data register and sets data-ready (status bit 0) on the next cycle.
- R3: A `rx_rd` strobe clears data-ready on the next cycle, unless a set hits it in the same cycle.
- R4: A control write with bit 2 equal to 0 clears overrun (status bit 1), framing error (status bit 2) and parity error (status bit 3) together.
- R5: A `tx_loaded` strobe sets transmit-empty (status bit 4) on the next cycle.
- R6: A `tx_we` strobe stores `tx_wdata` in the transmit holding register and clears transmit-empty, unless it is set in the same cycle.
- R7: `irq_tx` is 1 exactly when the transmit enable (control bit 1) and transmit-empty are both 1; it drops within one cycle of a control write that puts 0 in bit 1.
- R8: A `rx_done` strobe while data-ready is 1 and no read occurs in that cycle sets overrun and keeps the unread character in the received-data register.
- R9: A control write with bit 2 equal to 1 leaves every status flag unchanged.
- R10: When a set event and a clear event hit the same flag in one cycle, the flag ends up set.
- R11: `tx_load_req` is 1 whenever `tx_idle` is 1 and the holding register holds a character that has not yet been loaded; `tx_char` shows that character.
- R12: After reset the status reads 5'b10000, both enables are 0, both interrupt lines are 0 and `tx_load_req` is 0.
- R13: `rx_ferr` and `rx_perr` are sampled with `rx_done` and set the framing and parity error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | Receiver strobe: a character is complete |
| rx_char | input | DATA_W | Character that comes with `rx_done` |
| rx_ferr | input | 1 | Stop-bit error qualifier, valid with `rx_done` |
| rx_perr | input | 1 | Parity error qualifier, valid with `rx_done` |
| rx_rd | input | 1 | CPU read strobe of the received-data register |
| rx_rdata | output | DATA_W | Received-data register contents |
| tx_we | input | 1 | CPU write strobe of the transmit holding register |
| tx_wdata | input | DATA_W | Transmit data written by the CPU |
| tx_idle | input | 1 | Transmitter shift register is idle |
| tx_loaded | input | 1 | Transmitter strobe: holding register copied to shift register |
| tx_load_req | output | 1 | Request to the transmitter to take the held character |
| tx_char | output | DATA_W | Transmit holding register contents |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Bit 0 receive enable, bit 1 transmit enable, bit 2 error clear (active 0) |
| ctrl_en | output | 2 | Current enables: bit 0 receive, bit 1 transmit |
| status | output | 5 | Flags: bit 0 data-ready, 1 overrun, 2 framing, 3 parity, 4 transmit-empty |
| irq_rx | output | 1 | Receive interrupt request (level) |
| irq_tx | output | 1 | Transmit interrupt request (level) |

## Verification
The hardest conditions to reach are the same-cycle collisions. One is a data read arriving together with a new character. Another is the error-clear write landing together with an erroneous frame. The third is a transmit write coinciding with the transmitter's load strobe. Each ordinary sequence only ever produces one of these events per cycle. The bench therefore raises both strobes on the same falling edge, so that a single rising edge sees the set and the clear together, and then checks that the flag is set and which character is held.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

    // Receive flags, packed so that bit 0 is data-ready and bit 3 is parity.
    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic ovr_err;
        logic ready;
    } rx_flags_t;

    // Control write word: bit 0 rx enable, bit 1 tx enable, bit 2 error keep.
    typedef struct packed {
        logic err_keep;
        logic tx_en;
        logic rx_en;
    } ctrl_word_t;

    localparam int CTRL_W   = 3;
    localparam int STATUS_W = 5;

    function automatic logic rx_cause(input rx_flags_t f);
        return f.ready | f.ovr_err | f.frm_err | f.par_err;
    endfunction

endpackage

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
    import uart_flag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CTRL_W-1:0]    wdata,
    output logic                 rx_en,
    output logic                 tx_en,
    output logic                 err_clr
);
    ctrl_word_t word;
    assign word = ctrl_word_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else if (we) begin
            rx_en <= word.rx_en;
            tx_en <= word.tx_en;
        end
    end

    // Clear pulse only when a zero is written to the keep bit.
    assign err_clr = we & ~word.err_keep;
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_ferr,
    input  logic              rx_perr,
    input  logic              rd,
    input  logic              err_clr,
    input  logic              ctrl_we,
    input  logic              keep_bit,
    output rx_flags_t         flags,
    output logic [DATA_W-1:0] data
);
    logic overrun_ev;
    logic load_ev;

    assign overrun_ev = rx_done & flags.ready & ~rd;
    assign load_ev    = rx_done & ~overrun_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (load_ev) begin
            data <= rx_char;
        end
    end

    // Each flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (load_ev)      flags.ready <= 1'b1;
            else if (rd)      flags.ready <= 1'b0;

            if (overrun_ev)   flags.ovr_err <= 1'b1;
            else if (err_clr) flags.ovr_err <= 1'b0;

            if (rx_done && rx_ferr) flags.frm_err <= 1'b1;
            else if (err_clr)       flags.frm_err <= 1'b0;

            if (rx_done && rx_perr) flags.par_err <= 1'b1;
            else if (err_clr)       flags.par_err <= 1'b0;
        end
    end

    assert_ready_set_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !flags.ready) |=> (flags.ready && data == $past(rx_char)));

    assert_ready_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && !rx_done) |=> !flags.ready);

    assert_overrun_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_done && flags.ready && !rd) |=> (flags.ovr_err && $stable(data)));

    assert_err_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !keep_bit && !rx_done) |=>
            (!flags.ovr_err && !flags.frm_err && !flags.par_err));

    assert_keep_noeffect_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && keep_bit && !rx_done && !rd) |=> $stable(flags));
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_idle,
    input  logic              tx_loaded,
    output logic              empty,
    output logic              load_req,
    output logic [DATA_W-1:0] hold
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= '0;
            pending <= 1'b0;
            empty   <= 1'b1;
        end else begin
            if (wr) hold <= wdata;

            // A fresh write keeps data pending even if the old one was taken.
            if (wr)             pending <= 1'b1;
            else if (tx_loaded) pending <= 1'b0;

            if (tx_loaded)      empty <= 1'b1;
            else if (wr)        empty <= 1'b0;
        end
    end

    assign load_req = tx_idle & pending;

    assert_empty_set_R5: assert property (@(posedge clk) disable iff (rst)
        tx_loaded |=> empty);

    assert_empty_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && !tx_loaded) |=> (!empty && hold == $past(wdata)));
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
    import uart_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_done,
    input  logic [DATA_W-1:0]    rx_char,
    input  logic                 rx_ferr,
    input  logic                 rx_perr,
    input  logic                 rx_rd,
    output logic [DATA_W-1:0]    rx_rdata,
    input  logic                 tx_we,
    input  logic [DATA_W-1:0]    tx_wdata,
    input  logic                 tx_idle,
    input  logic                 tx_loaded,
    output logic                 tx_load_req,
    output logic [DATA_W-1:0]    tx_char,
    input  logic                 ctrl_we,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    output logic [1:0]           ctrl_en,
    output logic [STATUS_W-1:0]  status,
    output logic                 irq_rx,
    output logic                 irq_tx
);
    logic      rx_en, tx_en, err_clr;
    rx_flags_t rxf;
    logic      tx_empty;

    uart_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we      (ctrl_we),
        .wdata   (ctrl_wdata),
        .rx_en   (rx_en),
        .tx_en   (tx_en),
        .err_clr (err_clr)
    );

    uart_rx_flags #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_done  (rx_done),
        .rx_char  (rx_char),
        .rx_ferr  (rx_ferr),
        .rx_perr  (rx_perr),
        .rd       (rx_rd),
        .err_clr  (err_clr),
        .ctrl_we  (ctrl_we),
        .keep_bit (ctrl_wdata[2]),
        .flags    (rxf),
        .data     (rx_rdata)
    );

    uart_tx_flags #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .wr        (tx_we),
        .wdata     (tx_wdata),
        .tx_idle   (tx_idle),
        .tx_loaded (tx_loaded),
        .empty     (tx_empty),
        .load_req  (tx_load_req),
        .hold      (tx_char)
    );

    assign ctrl_en = {tx_en, rx_en};
    assign status  = {tx_empty, rxf};
    assign irq_rx  = rx_en & rx_cause(rxf);
    assign irq_tx  = tx_en & tx_empty;

    assert_rx_irq_off_R1: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !ctrl_wdata[0]) |=> !irq_rx);

    assert_tx_irq_off_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !ctrl_wdata[1]) |=> !irq_tx);
endmodule

// File: tb/uart_flag_irq_tb.sv
module uart_flag_irq_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_done = 0, rx_ferr = 0, rx_perr = 0, rx_rd = 0;
    logic [DW-1:0] rx_char = '0;
    logic [DW-1:0] rx_rdata;
    logic          tx_we = 0, tx_idle = 0, tx_loaded = 0;
    logic [DW-1:0] tx_wdata = '0;
    logic          tx_load_req;
    logic [DW-1:0] tx_char;
    logic          ctrl_we = 0;
    logic [2:0]    ctrl_wdata = 3'b100;
    logic [1:0]    ctrl_en;
    logic [4:0]    status;
    logic          irq_rx, irq_tx;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    uart_flag_irq #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .rx_done(rx_done), .rx_char(rx_char), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .tx_idle(tx_idle), .tx_loaded(tx_loaded),
        .tx_load_req(tx_load_req), .tx_char(tx_char),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_en(ctrl_en),
        .status(status), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All stimulus tasks start and end on a falling edge.
    task automatic rx_frame(input logic [DW-1:0] c, input logic fe, input logic pe);
        rx_done = 1; rx_char = c; rx_ferr = fe; rx_perr = pe;
        @(negedge clk);
        rx_done = 0; rx_ferr = 0; rx_perr = 0;
    endtask

    task automatic rd_data();
        rx_rd = 1;
        @(negedge clk);
        rx_rd = 0;
    endtask

    task automatic wr_ctrl(input logic rie, input logic tie, input logic keep);
        ctrl_we = 1; ctrl_wdata = {keep, tie, rie};
        @(negedge clk);
        ctrl_we = 0;
    endtask

    task automatic t_reset();
        check("R12 status", status, 5'b10000);
        check("R12 enables", ctrl_en, 2'b00);
        check("R12 irqs", {irq_rx, irq_tx}, 2'b00);
        check("R12 load_req", tx_load_req, 1'b0);
    endtask

    task automatic t_rx_basic();
        rx_frame(8'hA5, 0, 0);
        check("R2 ready", status[0], 1'b1);
        check("R2 data", rx_rdata, 8'hA5);
        check("R1 disabled", irq_rx, 1'b0);
        wr_ctrl(1, 0, 1);
        check("R1 enabled", irq_rx, 1'b1);
        rd_data();
        check("R3 ready cleared", status[0], 1'b0);
        check("R1 no cause", irq_rx, 1'b0);
    endtask

    task automatic t_overrun();
        rx_frame(8'h11, 0, 0);
        rx_frame(8'h22, 0, 0);
        check("R8 ovr", status[1], 1'b1);
        check("R8 kept", rx_rdata, 8'h11);
        rd_data();
        check("R3 ready after read", status[0], 1'b0);
        check("R1 error keeps irq", irq_rx, 1'b1);
        wr_ctrl(1, 0, 1);
        check("R9 keep write", status, 5'b10010);
        wr_ctrl(1, 0, 0);
        check("R4 cleared", status[3:1], 3'b000);
        check("R1 irq dropped", irq_rx, 1'b0);
    endtask

    task automatic t_errors();
        rx_frame(8'h5A, 1, 1);
        check("R13 fre pe", status[3:0], 4'b1101);
        rd_data();
        check("R13 errors remain", status[3:0], 4'b1100);
        wr_ctrl(0, 0, 1);
        check("R1 enable off", irq_rx, 1'b0);
        wr_ctrl(1, 0, 0);
        check("R4 all clear", status[3:0], 4'b0000);
    endtask

    task automatic t_collide();
        rx_frame(8'h44, 0, 0);
        rx_rd = 1;
        rx_frame(8'h55, 0, 0);
        rx_rd = 0;
        check("R10 ready set wins", status[1:0], 2'b01);
        check("R10 new data", rx_rdata, 8'h55);
        ctrl_we = 1; ctrl_wdata = 3'b001;
        rx_rd = 1;
        rx_frame(8'h66, 1, 0);
        ctrl_we = 0; rx_rd = 0;
        check("R10 fre set wins", status[3:0], 4'b0101);
        rd_data();
        wr_ctrl(0, 0, 0);
        check("R4 back to idle", status[3:0], 4'b0000);
    endtask

    task automatic t_tx();
        wr_ctrl(0, 1, 1);
        check("R7 empty irq", irq_tx, 1'b1);
        tx_idle = 0; tx_we = 1; tx_wdata = 8'h3C;
        @(negedge clk);
        tx_we = 0;
        check("R6 empty cleared", status[4], 1'b0);
        check("R6 hold", tx_char, 8'h3C);
        check("R7 irq off", irq_tx, 1'b0);
        check("R11 busy no req", tx_load_req, 1'b0);
        tx_idle = 1; #1;
        check("R11 req", tx_load_req, 1'b1);
        @(negedge clk);
        tx_loaded = 1; tx_idle = 0;
        @(negedge clk);
        tx_loaded = 0;
        check("R5 empty set", status[4], 1'b1);
        tx_idle = 1; #1;
        check("R11 no req after load", tx_load_req, 1'b0);
        tx_idle = 0;
        tx_we = 1; tx_wdata = 8'h77; tx_loaded = 1;
        @(negedge clk);
        tx_we = 0; tx_loaded = 0;
        check("R10 empty set wins", status[4], 1'b1);
        tx_idle = 1; #1;
        check("R11 new data pending", {tx_load_req, tx_char}, {1'b1, 8'h77});
        tx_loaded = 1;
        @(negedge clk);
        tx_loaded = 0; tx_idle = 0;
        wr_ctrl(0, 0, 1);
        check("R7 enable off", irq_tx, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_rx_basic();
        t_overrun();
        t_errors();
        t_collide();
        t_tx();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule